// File: doc/BRIEF.md
# Presettable Synchronous Up/Down Counter

A small binary counter whose state bits all change together on the rising clock edge. It steps by one when an active-low count enable is asserted. A single level-sensitive direction input chooses whether it counts up or down. Control inputs that change between edges have no effect on the stored value until the next rising edge.

An active-low load input places a parallel data word on the outputs at once, without waiting for a clock edge. While load is held, clock edges are ignored. Load is therefore both the way to initialise the counter and the way to preset a start value, so that a chain of stages divides by any modulus.

Two cascade outputs support chaining. A terminal-count flag is high when the count sits at the end of its range for the current direction. A gated ripple-clock output pulses low during the low phase of the clock when that flag is high and counting is enabled. Wider counters can be built by feeding the terminal-count flag of one stage into the enable of the next.

Top module: `presetCounter`

## Requirements
- R1: With countEnN low, dirDown low and loadN high, each rising clock edge increases countOut by one.
- R2: With countEnN low, dirDown high and loadN high, each rising clock edge decreases countOut by one.
- R3: With countEnN high and loadN high, rising clock edges leave countOut unchanged.
- R4: Counting up from the all-ones value (15 for the default 4 bits) gives 0.
- R5: Counting down from 0 gives the all-ones value.
- R6: While loadN is low, countOut equals dataIn without any clock edge, and follows dataIn when it changes.
- R7: While loadN is low, rising clock edges do not count, even with countEnN low. Counting resumes once loadN returns high.
- R8: termFlag is high exactly when countOut is all ones with dirDown low, or zero with dirDown high. It reacts to dirDown with no clock edge.
- R9: rippleClkN is low only while clk is low, termFlag is high and countEnN is low. Otherwise it is high.
- R10: Two stages sharing clk, dirDown and loadN form a 2*WIDTH-bit counter when the upper stage's enable is the lower stage's enable ORed with the inverse of the lower stage's termFlag. The combined value wraps in both directions.
- R11: A change on countEnN or dirDown between clock edges leaves countOut unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge active |
| countEnN | input | 1 | Active-low count enable |
| dirDown | input | 1 | Direction: 0 counts up, 1 counts down |
| loadN | input | 1 | Active-low asynchronous parallel load |
| dataIn | input | WIDTH | Preset value |
| countOut | output | WIDTH | Current count |
| termFlag | output | 1 | End of range for the current direction |
| rippleClkN | output | 1 | Active-low gated clock pulse for cascading |

## Verification
The hardest behaviour to reach from the ports is the interaction of the asynchronous load with the clock. The bench asserts load while the clock is high and checks the output before any edge arrives. It then holds load low across several edges with counting enabled and changes the data word in mid-phase, to show that the counter follows the data and does not count. The ripple output depends on the clock level itself, so the bench samples it in both clock phases of the same cycle at the terminal count. The two-stage chain is run through the carry and borrow points of the combined value.

// File: rtl/presetCounterPkg.sv
`timescale 1ns/1ps
package presetCounterPkg;
  // Strobes sent from the control decode to the datapath
  typedef struct packed {
    logic step;  // advance on this edge
    logic up;    // 1: increment, 0: decrement
  } stepCmd_t;
endpackage

// File: rtl/presetCounterCtrl.sv
`timescale 1ns/1ps
module presetCounterCtrl
  import presetCounterPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             countEnN,
  input  logic             dirDown,
  input  logic             loadN,
  input  logic [WIDTH-1:0] countQ,
  output stepCmd_t         cmd,
  output logic             termFlag,
  output logic             rippleClkN
);
  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT_VAL = '0;

  logic atTop;
  logic atBot;

  always_comb begin
    cmd.step = ~countEnN & loadN;
    cmd.up   = ~dirDown;
  end

  assign atTop      = (countQ == TOP_VAL);
  assign atBot      = (countQ == BOT_VAL);
  assign termFlag   = dirDown ? atBot : atTop;
  assign rippleClkN = ~(termFlag & ~countEnN & ~clk);

  // R9: a low ripple pulse seen before an edge implies terminal count with counting enabled
  a_r9_ripple_gate: assert property (@(posedge clk) disable iff (!loadN)
    !rippleClkN |-> (termFlag && !countEnN));
endmodule

// File: rtl/presetCounterDp.sv
`timescale 1ns/1ps
module presetCounterDp
  import presetCounterPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  input  stepCmd_t         cmd,
  output logic [WIDTH-1:0] countQ
);
  logic [WIDTH-1:0] nextCount;
  logic [WIDTH-1:0] setBit;
  logic [WIDTH-1:0] clrBit;

  assign nextCount = cmd.up ? countQ + WIDTH'(1) : countQ - WIDTH'(1);
  assign setBit    = {WIDTH{~loadN}} & dataIn;
  assign clrBit    = {WIDTH{~loadN}} & ~dataIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic bitQ;
    always_ff @(posedge clk or posedge setBit[i] or posedge clrBit[i]) begin
      if (clrBit[i])      bitQ <= 1'b0;
      else if (setBit[i]) bitQ <= 1'b1;
      else if (cmd.step)  bitQ <= nextCount[i];
    end
    assign countQ[i] = bitQ;
  end

  // R1 and R4: an enabled up step adds one, modulo the width
  a_r1_count_up: assert property (@(posedge clk) disable iff (!loadN)
    ($past(loadN) && $past(cmd.step) && $past(cmd.up))
      |-> countQ == WIDTH'($past(countQ) + WIDTH'(1)));

  // R2 and R5: an enabled down step subtracts one, modulo the width
  a_r2_count_down: assert property (@(posedge clk) disable iff (!loadN)
    ($past(loadN) && $past(cmd.step) && !$past(cmd.up))
      |-> countQ == WIDTH'($past(countQ) - WIDTH'(1)));

  // R3: without a step the stored value holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!loadN)
    ($past(loadN) && !$past(cmd.step)) |-> countQ == $past(countQ));
endmodule

// File: rtl/presetCounter.sv
`timescale 1ns/1ps
module presetCounter
  import presetCounterPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             countEnN,
  input  logic             dirDown,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] countOut,
  output logic             termFlag,
  output logic             rippleClkN
);
  stepCmd_t         cmd;
  logic [WIDTH-1:0] countQ;

  presetCounterCtrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .countEnN   (countEnN),
    .dirDown    (dirDown),
    .loadN      (loadN),
    .countQ     (countQ),
    .cmd        (cmd),
    .termFlag   (termFlag),
    .rippleClkN (rippleClkN)
  );

  presetCounterDp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .loadN  (loadN),
    .dataIn (dataIn),
    .cmd    (cmd),
    .countQ (countQ)
  );

  assign countOut = countQ;
endmodule

// File: tb/presetCounter_tb.sv
`timescale 1ns/1ps
module presetCounter_tb;
  logic       clk = 1'b0;
  logic       countEnN, dirDown, loadN;
  logic [3:0] dataIn;
  logic [3:0] countOut;
  logic       termFlag, rippleClkN;

  // cascade pair
  logic       cEnN, cDir, cLoadN;
  logic [7:0] cData;
  logic [3:0] loOut, hiOut;
  logic       loTerm, hiTerm, loRip, hiRip;
  logic       hiEnN;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  presetCounter #(.WIDTH(4)) u_dut (
    .clk(clk), .countEnN(countEnN), .dirDown(dirDown), .loadN(loadN),
    .dataIn(dataIn), .countOut(countOut), .termFlag(termFlag), .rippleClkN(rippleClkN));

  assign hiEnN = cEnN | ~loTerm;

  presetCounter #(.WIDTH(4)) u_lo (
    .clk(clk), .countEnN(cEnN), .dirDown(cDir), .loadN(cLoadN),
    .dataIn(cData[3:0]), .countOut(loOut), .termFlag(loTerm), .rippleClkN(loRip));

  presetCounter #(.WIDTH(4)) u_hi (
    .clk(clk), .countEnN(hiEnN), .dirDown(cDir), .loadN(cLoadN),
    .dataIn(cData[7:4]), .countOut(hiOut), .termFlag(hiTerm), .rippleClkN(hiRip));

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // lands 2 ns after a rising edge, clock high
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // load spanning one edge; output checked before that edge
  task automatic loadValue(input logic [3:0] d);
    loadN = 1'b0;
    dataIn = d;
    #1 chk("R6 immediate load", countOut, d);
    tick();
    loadN = 1'b1;
  endtask

  task automatic testReset();
    chk("R6 initial load", countOut, 0);
    chk("R8 zero in up mode", termFlag, 0);
    loadN = 1'b1;
  endtask

  task automatic testCountUp();
    countEnN = 1'b1; dirDown = 1'b0;
    loadValue(4'd3);
    countEnN = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      tick();
      chk("R1 count up", countOut, 3 + k);
    end
  endtask

  task automatic testWrapUp();
    countEnN = 1'b1; dirDown = 1'b0;
    loadValue(4'd14);
    countEnN = 1'b0;
    tick();
    chk("R4 reach 15", countOut, 15);
    chk("R8 flag at 15 up", termFlag, 1);
    tick();
    chk("R4 wrap to 0", countOut, 0);
    chk("R8 flag clear at 0 up", termFlag, 0);
  endtask

  task automatic testCountDown();
    countEnN = 1'b1; dirDown = 1'b1;
    loadValue(4'd9);
    countEnN = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      tick();
      chk("R2 count down", countOut, 9 - k);
    end
  endtask

  task automatic testWrapDown();
    countEnN = 1'b1; dirDown = 1'b1;
    loadValue(4'd1);
    countEnN = 1'b0;
    tick();
    chk("R5 reach 0", countOut, 0);
    chk("R8 flag at 0 down", termFlag, 1);
    dirDown = 1'b0;
    #1 chk("R8 flag follows direction", termFlag, 0);
    dirDown = 1'b1;
    #1 chk("R8 flag back on", termFlag, 1);
    tick();
    chk("R5 wrap to 15", countOut, 15);
  endtask

  task automatic testHold();
    countEnN = 1'b1; dirDown = 1'b0;
    loadValue(4'd7);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R3 hold", countOut, 7);
    end
    countEnN = 1'b0; dirDown = 1'b1;
    #2 chk("R11 no change before edge", countOut, 7);
    tick();
    chk("R11 applied at edge", countOut, 6);
  endtask

  task automatic testLoadPriority();
    countEnN = 1'b0; dirDown = 1'b0;
    loadN = 1'b0; dataIn = 4'd5;
    #1 chk("R6 load while clock high", countOut, 5);
    tick();
    chk("R7 edge ignored", countOut, 5);
    tick();
    chk("R7 second edge ignored", countOut, 5);
    dataIn = 4'd10;
    #1 chk("R6 follows data", countOut, 10);
    loadN = 1'b1;
    #1 chk("R7 released, no edge yet", countOut, 10);
    tick();
    chk("R7 counting resumes", countOut, 11);
  endtask

  task automatic testRipple();
    countEnN = 1'b1; dirDown = 1'b0;
    loadValue(4'd14);
    countEnN = 1'b0;
    tick();
    chk("R9 high while clock high", rippleClkN, 1);
    #5 chk("R9 low in low phase at max", rippleClkN, 0);
    countEnN = 1'b1;
    #1 chk("R9 high when disabled", rippleClkN, 1);
    tick();
    countEnN = 1'b0;
    tick();
    chk("R4 wrap before ripple check", countOut, 0);
    #5 chk("R9 high when not terminal", rippleClkN, 1);
  endtask

  task automatic testCascade();
    cEnN = 1'b1; cDir = 1'b0; cLoadN = 1'b0; cData = 8'hFE;
    tick();
    cLoadN = 1'b1;
    cEnN = 1'b0;
    tick(); chk("R10 up to FF", {hiOut, loOut}, 8'hFF);
    tick(); chk("R10 wrap up to 00", {hiOut, loOut}, 8'h00);
    tick(); chk("R10 up to 01", {hiOut, loOut}, 8'h01);
    cEnN = 1'b1; cLoadN = 1'b0; cData = 8'h2F;
    tick();
    cLoadN = 1'b1; cEnN = 1'b0;
    tick(); chk("R10 carry into upper", {hiOut, loOut}, 8'h30);
    cDir = 1'b1;
    tick(); chk("R10 borrow from upper", {hiOut, loOut}, 8'h2F);
    cEnN = 1'b1; cLoadN = 1'b0; cData = 8'h01;
    tick();
    cLoadN = 1'b1; cEnN = 1'b0;
    tick(); chk("R10 down to 00", {hiOut, loOut}, 8'h00);
    tick(); chk("R10 wrap down to FF", {hiOut, loOut}, 8'hFF);
    cEnN = 1'b1;
  endtask

  initial begin
    countEnN = 1'b1; dirDown = 1'b0; loadN = 1'b0; dataIn = 4'd0;
    cEnN = 1'b1; cDir = 1'b0; cLoadN = 1'b0; cData = 8'h00;
    tick();
    tick();
    testReset();
    testCountUp();
    testWrapUp();
    testCountDown();
    testWrapDown();
    testHold();
    testLoadPriority();
    testRipple();
    testCascade();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule